// File: doc/BRIEF.md
# Cascaded Polarity-Configurable Interrupt Controller

This block collects interrupt requests from three groups of sources and presents one interrupt line to a processor. Each group has its own controller with a per-source enable mask. Each source also has two independent configuration bits, activation polarity and activation type. Together they make a source sensitive to a high level, a low level, a rising edge or a falling edge. Every source input passes through a synchroniser first. Edge-type sources are held in a latch until software acknowledges them by writing a one to their raw status bit. Level-type sources show the corrected input level directly.

Two of the controllers are sub-controllers. Each one's interrupt output drives a fixed input of the main controller, and only the main controller's output leaves the block. With NSRC sources per controller, source numbers 0 to NSRC-1 belong to the main controller, NSRC to 2·NSRC-1 to the first sub-controller, and 2·NSRC to 3·NSRC-1 to the second. Software reaches all three controllers through a small register bus. It reads the masked status to find pending sources, then acknowledges edge sources through the raw status register.

Top module: `pol_intc_top`

## Requirements
- R1: After reset, every controller has mask all zeros, polarity all ones and type all zeros, `irq` is 0 and `bus_rdata` is 0.
- R2: A source with polarity 1 and type 0 is high-level sensitive. Its raw status bit equals its synchronised input, and the status register holds raw AND mask.
- R3: A source with polarity 0 and type 0 is low-level sensitive. Its raw status bit is the inverse of its synchronised input.
- R4: A source with polarity 1 and type 1 sets its raw bit on a 0-to-1 transition of the synchronised input. The bit stays set after the input returns to 0.
- R5: A source with polarity 0 and type 1 sets its raw bit on a 1-to-0 transition. A 0-to-1 transition does not set it.
- R6: Writing the raw status register clears each latched edge bit whose write-data bit is 1. Bits written 0 keep their state. A new edge in the same cycle as a clear keeps the bit set.
- R7: Writing 1 to the raw bit of a level-type source has no lasting effect while its input stays active.
- R8: `irq` is 1 only when some bit of the main status (raw AND mask) is 1. Writing 0 to the mask register removes every source of that controller from the status register.
- R9: Sub-controller 1's output drives main input CASC1_IDX and sub-controller 2's drives main input CASC2_IDX. The `src_main` bits at those positions are ignored.
- R10: `bus_addr[4:3]` selects the controller: 0 main, 1 sub 1, 2 sub 2, 3 none (reads 0). `bus_addr[2:0]` selects the register: 0 mask, 1 raw status, 2 status (read-only, writes ignored), 3 polarity, 4 type; other values read 0. Writes take effect at the clock edge. `bus_rdata` updates only at the edge that ends a cycle with `bus_rd` high, and holds otherwise.
- R11: `irq` is registered. It changes one clock after the main status changes between zero and nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_main | input | NSRC | Main controller source inputs (cascade positions ignored) |
| src_sub1 | input | NSRC | Sub-controller 1 source inputs |
| src_sub2 | input | NSRC | Sub-controller 2 source inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Controller select [4:3], register select [2:0] |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NSRC=8, CASC1_IDX=6, CASC2_IDX=7 and SYNC_STAGES=2. At that width a single register value covers every bit, so the bench can observe the whole mask, raw and status vector at once. Both cascade positions sit inside that vector, so it can check that a forced `src_main` bit at a cascade position stays invisible while the sub-controller drives the line. The short synchroniser also keeps the full path, from a sub-controller source to `irq`, within a few cycles, so edge, level and acknowledge interactions are each timed exactly.

// File: rtl/pol_intc_pkg.sv
package pol_intc_pkg;
  localparam int ADDR_W = 5;

  localparam logic [2:0] RG_MASK = 3'd0;
  localparam logic [2:0] RG_RAW  = 3'd1;
  localparam logic [2:0] RG_STAT = 3'd2;
  localparam logic [2:0] RG_POL  = 3'd3;
  localparam logic [2:0] RG_TYPE = 3'd4;

  localparam logic [1:0] CT_MAIN = 2'd0;
  localparam logic [1:0] CT_SUB1 = 2'd1;
  localparam logic [1:0] CT_SUB2 = 2'd2;

  localparam int NUNIT = 3;
endpackage

// File: rtl/pol_intc_src_cell.sv
module pol_intc_src_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic pol,
  input  logic edge_mode,
  input  logic clr,
  output logic raw
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q;
  logic lat_q, lat_d;
  logic smp, act, hit;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], din};
    smp    = sync_q[SYNC_STAGES-1];
    act    = ~(smp ^ pol);
    hit    = pol ? (smp & ~prev_q) : (~smp & prev_q);
    // a fresh edge wins over an acknowledge in the same cycle
    lat_d  = edge_mode & (hit | (lat_q & ~clr));
    raw    = edge_mode ? lat_q : act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= smp;
      lat_q  <= lat_d;
    end
  end
endmodule

// File: rtl/pol_intc_unit.sv
module pol_intc_unit
  import pol_intc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic [2:0]      reg_sel,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pol_q,
  output logic [NSRC-1:0] type_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] status,
  output logic            irq_q
);
  logic            mask_en, pol_en, type_en;
  logic [NSRC-1:0] clr_vec;
  logic            irq_d;

  always_comb begin
    mask_en = wr_en && (reg_sel == RG_MASK);
    pol_en  = wr_en && (reg_sel == RG_POL);
    type_en = wr_en && (reg_sel == RG_TYPE);
    clr_vec = (wr_en && (reg_sel == RG_RAW)) ? wdata : '0;
    status  = raw & mask_q;
    irq_d   = |status;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    pol_intc_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (src[i]),
      .pol       (pol_q[i]),
      .edge_mode (type_q[i]),
      .clr       (clr_vec[i]),
      .raw       (raw[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= '1;
      type_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= wdata;
      if (pol_en)  pol_q  <= wdata;
      if (type_en) type_q <= wdata;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/pol_intc_top.sv
module pol_intc_top
  import pol_intc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CASC1_IDX   = 30,
  parameter int CASC2_IDX   = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_main,
  input  logic [NSRC-1:0]     src_sub1,
  input  logic [NSRC-1:0]     src_sub2,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NSRC-1:0]     bus_wdata,
  output logic [NSRC-1:0]     bus_rdata,
  output logic                irq
);
  logic [1:0]      ctl_sel;
  logic [2:0]      reg_sel;
  logic [NSRC-1:0] u_src  [NUNIT];
  logic [NSRC-1:0] u_mask [NUNIT];
  logic [NSRC-1:0] u_pol  [NUNIT];
  logic [NSRC-1:0] u_type [NUNIT];
  logic [NSRC-1:0] u_raw  [NUNIT];
  logic [NSRC-1:0] u_stat [NUNIT];
  logic            u_irq  [NUNIT];
  logic [NSRC-1:0] rd_d, rdata_q;
  logic [NSRC-1:0] main_mask, main_type, main_raw, main_stat;

  always_comb begin
    ctl_sel  = bus_addr[4:3];
    reg_sel  = bus_addr[2:0];
    u_src[0] = src_main;
    u_src[0][CASC1_IDX] = u_irq[1];
    u_src[0][CASC2_IDX] = u_irq[2];
    u_src[1] = src_sub1;
    u_src[2] = src_sub2;
  end

  for (genvar k = 0; k < NUNIT; k++) begin : g_unit
    pol_intc_unit #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (u_src[k]),
      .wr_en   (bus_wr && (ctl_sel == 2'(k))),
      .reg_sel (reg_sel),
      .wdata   (bus_wdata),
      .mask_q  (u_mask[k]),
      .pol_q   (u_pol[k]),
      .type_q  (u_type[k]),
      .raw     (u_raw[k]),
      .status  (u_stat[k]),
      .irq_q   (u_irq[k])
    );
  end

  function automatic logic [NSRC-1:0] pick(
    input logic [2:0] rs, input logic [NSRC-1:0] m, input logic [NSRC-1:0] r,
    input logic [NSRC-1:0] s, input logic [NSRC-1:0] p, input logic [NSRC-1:0] t);
    case (rs)
      RG_MASK: return m;
      RG_RAW:  return r;
      RG_STAT: return s;
      RG_POL:  return p;
      RG_TYPE: return t;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    case (ctl_sel)
      CT_MAIN: rd_d = pick(reg_sel, u_mask[0], u_raw[0], u_stat[0], u_pol[0], u_type[0]);
      CT_SUB1: rd_d = pick(reg_sel, u_mask[1], u_raw[1], u_stat[1], u_pol[1], u_type[1]);
      CT_SUB2: rd_d = pick(reg_sel, u_mask[2], u_raw[2], u_stat[2], u_pol[2], u_type[2]);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  always_comb begin
    bus_rdata = rdata_q;
    irq       = u_irq[0];
    main_mask = u_mask[0];
    main_type = u_type[0];
    main_raw  = u_raw[0];
    main_stat = u_stat[0];
  end
endmodule

// File: rtl/pol_intc_checker.sv
module pol_intc_checker
  import pol_intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_wdata,
  input logic [NSRC-1:0]   bus_rdata,
  input logic              irq,
  input logic [NSRC-1:0]   mask_m,
  input logic [NSRC-1:0]   type_m,
  input logic [NSRC-1:0]   raw_m,
  input logic [NSRC-1:0]   stat_m
);
  logic [NSRC-1:0] clr_m;
  assign clr_m = (bus_wr && bus_addr == {CT_MAIN, RG_RAW}) ? bus_wdata : '0;

  assert_status_in_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_m & ~mask_m) == '0);

  assert_mask_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_m) == '0) |-> !irq);

  assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(stat_m) != '0));

  assert_edge_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(raw_m & type_m & ~clr_m) & type_m & ~raw_m) == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind pol_intc_top pol_intc_checker #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .mask_m    (main_mask),
  .type_m    (main_type),
  .raw_m     (main_raw),
  .stat_m    (main_stat)
);

// File: tb/pol_intc_top_test.sv
module pol_intc_top_test;
  localparam int N = 8;
  localparam logic [1:0] CM = 2'd0, C1 = 2'd1, C2 = 2'd2;
  localparam logic [2:0] GM = 3'd0, GR = 3'd1, GS = 3'd2, GP = 3'd3, GT = 3'd4;

  logic         clk, rst_n;
  logic [N-1:0] s_main, s_sub1, s_sub2;
  logic         bus_wr, bus_rd;
  logic [4:0]   bus_addr;
  logic [N-1:0] bus_wdata, bus_rdata;
  logic         irq;
  int           total, bad;
  logic [N-1:0] v;

  pol_intc_top #(.NSRC(N), .SYNC_STAGES(2), .CASC1_IDX(6), .CASC2_IDX(7)) uut (
    .clk(clk), .rst_n(rst_n), .src_main(s_main), .src_sub1(s_sub1), .src_sub2(s_sub2),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] c, input logic [2:0] r, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = {c, r}; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] c, input logic [2:0] r, output logic [N-1:0] d);
    bus_rd = 1'b1; bus_addr = {c, r};
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(CM, GM, v); chk("R1 mask", v, 8'h00);
    rd(CM, GP, v); chk("R1 pol", v, 8'hFF);
    rd(C2, GT, v); chk("R1 type sub2", v, 8'h00);
  endtask

  task automatic t_high_level;
    wr(CM, GM, 8'h01);
    s_main[0] = 1'b1; idle(5);
    rd(CM, GR, v); chk("R2 raw high", v, 8'h01);
    rd(CM, GS, v); chk("R2 status", v, 8'h01);
    chk("R2 irq high", irq, 1);
    s_main[0] = 1'b0; idle(5);
    rd(CM, GR, v); chk("R2 raw low", v, 8'h00);
    chk("R2 irq low", irq, 0);
    wr(CM, GM, 8'h00);
  endtask

  task automatic t_low_level;
    s_main[1] = 1'b1;
    wr(CM, GP, 8'hFD); wr(CM, GM, 8'h02); idle(5);
    chk("R3 inactive irq", irq, 0);
    s_main[1] = 1'b0; idle(5);
    rd(CM, GR, v); chk("R3 raw", v, 8'h02);
    chk("R3 irq", irq, 1);
    wr(CM, GP, 8'hFF); wr(CM, GM, 8'h00); idle(3);
  endtask

  task automatic t_rising;
    wr(CM, GT, 8'h04); wr(CM, GM, 8'h04);
    s_main[2] = 1'b1; idle(5);
    rd(CM, GR, v); chk("R4 latched", v, 8'h04);
    s_main[2] = 1'b0; idle(5);
    rd(CM, GR, v); chk("R4 held", v, 8'h04);
    chk("R4 irq held", irq, 1);
    wr(CM, GR, 8'hFB); idle(2);
    rd(CM, GR, v); chk("R6 zero bit keeps", v, 8'h04);
    wr(CM, GR, 8'h04); idle(2);
    rd(CM, GR, v); chk("R6 cleared", v, 8'h00);
    chk("R6 irq drop", irq, 0);
    wr(CM, GM, 8'h00); wr(CM, GT, 8'h00);
  endtask

  task automatic t_falling;
    wr(CM, GT, 8'h08); wr(CM, GP, 8'hF7); wr(CM, GM, 8'h08);
    s_main[3] = 1'b1; idle(5);
    rd(CM, GR, v); chk("R5 rise ignored", v, 8'h00);
    chk("R5 irq quiet", irq, 0);
    s_main[3] = 1'b0; idle(5);
    rd(CM, GR, v); chk("R5 fall latched", v, 8'h08);
    chk("R5 irq", irq, 1);
    wr(CM, GR, 8'h08); idle(2);
    rd(CM, GR, v); chk("R6 fall cleared", v, 8'h00);
    wr(CM, GM, 8'h00); wr(CM, GT, 8'h00); wr(CM, GP, 8'hFF);
  endtask

  task automatic t_level_w1c;
    wr(CM, GM, 8'h01);
    s_main[0] = 1'b1; idle(5);
    wr(CM, GR, 8'h01); idle(3);
    rd(CM, GR, v); chk("R7 raw stays", v, 8'h01);
    chk("R7 irq stays", irq, 1);
    s_main[0] = 1'b0;
    wr(CM, GM, 8'h00); idle(5);
  endtask

  task automatic t_mask;
    s_main[4] = 1'b1; idle(5);
    rd(CM, GR, v); chk("R8 raw unmasked", v, 8'h10);
    rd(CM, GS, v); chk("R8 status masked", v, 8'h00);
    chk("R8 irq masked", irq, 0);
    wr(CM, GM, 8'h10);
    chk("R11 irq one cycle later", irq, 0);
    idle(1);
    chk("R11 irq rises", irq, 1);
    rd(CM, GS, v); chk("R8 status", v, 8'h10);
    wr(CM, GM, 8'h00); idle(1);
    chk("R8 mask zero irq", irq, 0);
    rd(CM, GS, v); chk("R8 status cleared", v, 8'h00);
    s_main[4] = 1'b0; idle(5);
  endtask

  task automatic t_cascade;
    wr(C1, GM, 8'h01);
    s_sub1[0] = 1'b1; idle(10);
    rd(C1, GS, v); chk("R9 sub1 status", v, 8'h01);
    rd(CM, GR, v); chk("R9 main raw bit6", v, 8'h40);
    chk("R9 main masked", irq, 0);
    wr(CM, GM, 8'h40); idle(3);
    chk("R9 irq via sub1", irq, 1);
    s_main[6] = 1'b1; s_sub1[0] = 1'b0; idle(10);
    rd(CM, GR, v); chk("R9 src bit ignored", v, 8'h00);
    chk("R9 irq off", irq, 0);
    s_main[6] = 1'b0;
    wr(C2, GM, 8'h20); wr(CM, GM, 8'h80);
    s_sub2[5] = 1'b1; idle(10);
    chk("R9 irq via sub2", irq, 1);
    rd(CM, GR, v); chk("R9 main raw bit7", v, 8'h80);
    s_sub2[5] = 1'b0;
    wr(CM, GM, 8'h00); wr(C1, GM, 8'h00); wr(C2, GM, 8'h00); idle(10);
  endtask

  task automatic t_bus;
    wr(CM, GS, 8'hFF);
    rd(CM, GS, v); chk("R10 status write ignored", v, 8'h00);
    rd(CM, 3'd5, v); chk("R10 unmapped reg", v, 8'h00);
    rd(2'd3, GP, v); chk("R10 unmapped ctl", v, 8'h00);
    rd(C1, GP, v); chk("R10 sub1 pol", v, 8'hFF);
    wr(C1, GP, 8'h5A); idle(2);
    chk("R10 rdata holds", bus_rdata, 8'hFF);
    rd(C1, GP, v); chk("R10 new pol", v, 8'h5A);
    rd(CM, GP, v); chk("R10 main pol separate", v, 8'hFF);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; s_main = '0; s_sub1 = '0; s_sub2 = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_high_level;
    t_low_level;
    t_rising;
    t_falling;
    t_level_w1c;
    t_mask;
    t_cascade;
    t_bus;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule